// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Path

The block collects 32 level-sensitive interrupt lines and presents them to a processor core. Line 0 is not connected. Lines 1 to 29 are maskable. Their levels are captured in a raw pending word. A software-written enable word gates the raw word, and the result is the masked pending word. The masked word drives one interrupt request output and an 8-bit vector bus.

When exactly one masked source is pending, the vector bus names that source. When several are pending, the bus carries one shared code, and software reads the masked word to decide which source to serve first. Lines 30 and 31 bypass the enable word. They set bits in a separate non-maskable status word, which drives its own request output.

A 32-bit register port, addressed in bytes, gives read access to all of these words. The only writable word is the enable word. Every state element, and every output of the vector path, is updated on the same rising clock edge that samples the inputs.

Top module: `intr_vector_ctrl`

## Requirements
- R1: After synchronous reset, the enable, raw, masked and non-maskable words all read 0, `vecOut` is 0, and both `irqReq` and `nmiReq` are low.
- R2: A write with `regWe` high at byte address 0 loads `regWrData` into the enable word. The enable word is read back at byte address 0.
- R3: A write to any byte address other than 0 changes no state. This includes misaligned address 1 and word addresses 1 and 2.
- R4: The raw word (byte address 4) holds the level of line n in bit n-1, for n from 1 to 29. Bits 29 to 31 read 0, and line 0 has no effect.
- R5: The masked word (byte address 8) reads as raw AND enable at all times.
- R6: When exactly bit i of the masked word is set, `vecOut` is 0x31+i and `irqReq` is high.
- R7: When two or more bits of the masked word are set, `vecOut` is 0x30 and `irqReq` is high.
- R8: When the masked word is zero, `vecOut` is 0 and `irqReq` is low.
- R9: The non-maskable word (byte address 12) holds the level of line 30 in bit 30 and the level of line 31 in bit 31. All its other bits read 0.
- R10: `nmiReq` is high exactly when the non-maskable word is nonzero, whatever the enable word holds.
- R11: `vecOut`, `irqReq` and `nmiReq` change on the first rising edge after an input level or enable write is presented, and not before that edge.
- R12: Byte address 16 (the reserved diagnostic word) and every higher address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| irqLines | input | 32 | Interrupt levels; bit n is line n |
| regAddr | input | 5 | Byte address of the register port |
| regWe | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from the address |
| vecOut | output | 8 | Vector code, registered |
| irqReq | output | 1 | Maskable request, registered |
| nmiReq | output | 1 | Non-maskable request, registered |

## Verification
Every output of the vector path, and every status word, is due on the first rising edge after the stimulus is presented on a falling edge. A driver task computes the expected vector, request and non-maskable values from its own model and queues them. A monitor pops one entry a quarter period after each rising edge and compares it. Just before that edge, the driver also confirms that the outputs still hold their previous values. Register reads are combinational, so they are checked after the edge and before the next falling edge, once the new state has settled.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int ADDR_W = 5;
  localparam int SEL_W  = ADDR_W - 2;

  localparam logic [SEL_W-1:0] SEL_ENABLE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_RAW    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MASKED = 3'd2;
  localparam logic [SEL_W-1:0] SEL_NMI    = 3'd3;

  typedef struct packed {
    logic             enableWr;
    logic [SEL_W-1:0] rdSel;
  } strobe_t;
endpackage

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output strobe_t           strobes
);
  logic [SEL_W-1:0] wordIdx;
  logic             aligned;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    strobes.enableWr = regWe && aligned && (wordIdx == SEL_ENABLE);
    strobes.rdSel    = wordIdx;
  end
endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NMI_LINES = 2,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] SHARED_CODE = 8'h30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [NUM_LINES-1:0] regWrData,
  input  strobe_t              strobes,
  output logic [NUM_LINES-1:0] regRdData,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 irqReq,
  output logic                 nmiReq
);
  localparam int MASKABLE = NUM_LINES - NMI_LINES - 1;
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] enableReg, rawReg, nmiReg;
  logic [NUM_LINES-1:0] enableNext, rawNext, nmiNext, maskedNext;
  logic [IDX_W-1:0]     lowIdx;
  logic                 found, multi;
  logic [VEC_W-1:0]     vecNext;
  logic                 unusedLine0;

  assign unusedLine0 = irqLines[0];

  always_comb begin
    enableNext = strobes.enableWr ? regWrData : enableReg;
    rawNext = '0;
    rawNext[MASKABLE-1:0] = irqLines[MASKABLE:1];
    nmiNext = '0;
    nmiNext[NUM_LINES-1:NUM_LINES-NMI_LINES] = irqLines[NUM_LINES-1:NUM_LINES-NMI_LINES];
    maskedNext = rawNext & enableNext;
  end

  always_comb begin
    lowIdx = '0;
    found  = 1'b0;
    multi  = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (maskedNext[i]) begin
        if (found) multi = 1'b1;
        else begin
          lowIdx = IDX_W'(i);
          found  = 1'b1;
        end
      end
    end
    if (!found)     vecNext = '0;
    else if (multi) vecNext = SHARED_CODE;
    else            vecNext = SHARED_CODE + VEC_W'(1) + VEC_W'(lowIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enableReg <= '0;
      rawReg    <= '0;
      nmiReg    <= '0;
      vecOut    <= '0;
      irqReq    <= 1'b0;
      nmiReq    <= 1'b0;
    end else begin
      enableReg <= enableNext;
      rawReg    <= rawNext;
      nmiReg    <= nmiNext;
      vecOut    <= vecNext;
      irqReq    <= found;
      nmiReq    <= |nmiNext;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_ENABLE: regRdData = enableReg;
      SEL_RAW:    regRdData = rawReg;
      SEL_MASKED: regRdData = rawReg & enableReg;
      SEL_NMI:    regRdData = nmiReg;
      default:    regRdData = '0;
    endcase
  end

  a_r8_req_iff_code: assert property (@(posedge clk) disable iff (rst)
    irqReq == (vecOut != '0));
  a_r7_shared_has_req: assert property (@(posedge clk) disable iff (rst)
    (vecOut == SHARED_CODE) |-> irqReq);
  a_r6_code_in_range: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> (vecOut >= SHARED_CODE && vecOut <= SHARED_CODE + VEC_W'(MASKABLE)));
  a_r10_nmi_follows_status: assert property (@(posedge clk) disable iff (rst)
    nmiReq == (nmiReg != '0));
  a_r2_enable_loads: assert property (@(posedge clk) disable iff (rst)
    (strobes.enableWr && !rst) |=> enableReg == $past(regWrData));
  a_r3_enable_holds: assert property (@(posedge clk) disable iff (rst)
    (!strobes.enableWr && !rst) |=> $stable(enableReg));
  a_r4_raw_tracks_lines: assert property (@(posedge clk) disable iff (rst)
    !rst |=> rawReg[MASKABLE-1:0] == $past(irqLines[MASKABLE:1]));
  a_r4_raw_top_zero: assert property (@(posedge clk) disable iff (rst)
    rawReg[NUM_LINES-1:MASKABLE] == '0);
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import intr_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NMI_LINES = 2,
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 irqReq,
  output logic                 nmiReq
);
  strobe_t strobes;

  intr_ctrl u_ctrl (
    .regAddr(regAddr),
    .regWe(regWe),
    .strobes(strobes)
  );

  intr_datapath #(
    .NUM_LINES(NUM_LINES),
    .NMI_LINES(NMI_LINES),
    .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .irqLines(irqLines),
    .regWrData(regWrData),
    .strobes(strobes),
    .regRdData(regRdData),
    .vecOut(vecOut),
    .irqReq(irqReq),
    .nmiReq(nmiReq)
  );
endmodule

// File: tb/intr_vector_ctrl_test.sv
module intr_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irqLines = '0;
  logic [4:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  vecOut;
  logic        irqReq, nmiReq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] vec;
    logic       req;
    logic       nmi;
    int         ones;
  } exp_t;
  exp_t sb[$];

  logic [31:0] mdlEnable = '0;
  logic [31:0] mdlRaw = '0;
  logic [31:0] mdlNmi = '0;
  logic [7:0]  lastVec = '0;
  logic        lastReq = 1'b0, lastNmi = 1'b0;

  intr_vector_ctrl uut (
    .clk(clk), .rst(rst), .irqLines(irqLines), .regAddr(regAddr),
    .regWe(regWe), .regWrData(regWrData), .regRdData(regRdData),
    .vecOut(vecOut), .irqReq(irqReq), .nmiReq(nmiReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] lines, input logic we,
                      input logic [4:0] addr, input logic [31:0] data);
    exp_t e;
    logic [31:0] masked;
    int low;
    @(negedge clk);
    irqLines = lines; regWe = we; regAddr = addr; regWrData = data;
    if (we && addr == 5'd0) mdlEnable = data;
    mdlRaw = {3'b000, lines[29:1]};
    mdlNmi = {lines[31:30], 30'b0};
    masked = mdlRaw & mdlEnable;
    e.ones = 0; low = 0;
    for (int i = 31; i >= 0; i--) if (masked[i]) begin e.ones++; low = i; end
    e.vec = (e.ones == 0) ? 8'h00 : (e.ones > 1) ? 8'h30 : 8'(8'h31 + low);
    e.req = (e.ones != 0);
    e.nmi = (mdlNmi != 0);
    sb.push_back(e);
    #1;
    check("R11 vec early", {24'b0, vecOut}, {24'b0, lastVec});
    check("R11 req early", {31'b0, irqReq}, {31'b0, lastReq});
    check("R11 nmi early", {31'b0, nmiReq}, {31'b0, lastNmi});
    lastVec = e.vec; lastReq = e.req; lastNmi = e.nmi;
    @(posedge clk);
    #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] addr, input logic [31:0] exp, input string tag);
    regAddr = addr;
    #1;
    check(tag, regRdData, exp);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (!rst && sb.size() > 0) begin
        e = sb.pop_front();
        if (e.ones == 0)     check("R8 vec idle", {24'b0, vecOut}, {24'b0, e.vec});
        else if (e.ones > 1) check("R7 vec shared", {24'b0, vecOut}, {24'b0, e.vec});
        else                 check("R6 vec single", {24'b0, vecOut}, {24'b0, e.vec});
        check("R8 irqReq", {31'b0, irqReq}, {31'b0, e.req});
        check("R10 nmiReq", {31'b0, nmiReq}, {31'b0, e.nmi});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 vecOut", {24'b0, vecOut}, 32'h0);
    check("R1 irqReq", {31'b0, irqReq}, 32'h0);
    check("R1 nmiReq", {31'b0, nmiReq}, 32'h0);
    rd(5'd0, 32'h0, "R1 enable");
    rd(5'd4, 32'h0, "R1 raw");
    rd(5'd12, 32'h0, "R1 nmi");

    // R2 enable write and readback
    step(32'h0, 1'b1, 5'd0, 32'hFFFF_FFFF);
    rd(5'd0, 32'hFFFF_FFFF, "R2 enable readback");

    // R6 single sources at both ends
    step(32'h0000_0002, 1'b0, 5'd0, 32'h0);
    rd(5'd4, 32'h0000_0001, "R4 line1 bit0");
    step(32'h2000_0000, 1'b0, 5'd0, 32'h0);
    rd(5'd4, 32'h1000_0000, "R4 line29 bit28");
    rd(5'd8, 32'h1000_0000, "R5 masked");

    // R7 several sources
    step(32'h0000_0106, 1'b0, 5'd0, 32'h0);
    rd(5'd8, 32'h0000_0083, "R5 masked multi");

    // enable filters down to a single source (R5, R6)
    step(32'h0000_0106, 1'b1, 5'd0, 32'h0000_0080);
    rd(5'd8, 32'h0000_0080, "R5 masked filtered");

    // R8 enable cleared
    step(32'h0000_0106, 1'b1, 5'd0, 32'h0);
    rd(5'd8, 32'h0, "R5 masked zero");
    rd(5'd4, 32'h0000_0083, "R4 raw kept");

    // R4 line 0 ignored
    step(32'h0000_0001, 1'b1, 5'd0, 32'hFFFF_FFFF);
    rd(5'd4, 32'h0, "R4 line0 ignored");

    // R9 R10 non-maskable lines, enable cleared
    step(32'h4000_0000, 1'b1, 5'd0, 32'h0);
    rd(5'd12, 32'h4000_0000, "R9 line30");
    rd(5'd4, 32'h0, "R4 raw excludes nmi");
    step(32'h8000_0000, 1'b0, 5'd0, 32'h0);
    rd(5'd12, 32'h8000_0000, "R9 line31");
    step(32'hC000_0000, 1'b1, 5'd0, 32'hFFFF_FFFF);
    rd(5'd12, 32'hC000_0000, "R9 both");
    rd(5'd8, 32'h0, "R5 nmi not masked path");
    step(32'h0, 1'b0, 5'd0, 32'h0);

    // R3 writes elsewhere ignored
    step(32'h0000_0010, 1'b1, 5'd4, 32'h0);
    rd(5'd0, 32'hFFFF_FFFF, "R3 word1 write ignored");
    step(32'h0000_0010, 1'b1, 5'd1, 32'h0);
    rd(5'd0, 32'hFFFF_FFFF, "R3 misaligned ignored");
    step(32'h0000_0010, 1'b1, 5'd8, 32'h0);
    rd(5'd8, 32'h0000_0008, "R3 masked write ignored");
    rd(5'd4, 32'h0000_0008, "R3 raw intact");

    // R12 reserved and unmapped words
    rd(5'd16, 32'h0, "R12 diag word");
    rd(5'd20, 32'h0, "R12 unmapped");
    rd(5'd28, 32'h0, "R12 top");

    step(32'h0, 1'b0, 5'd0, 32'h0);
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule